// File: doc/BRIEF.md
# Output Word Rounder with Dither and Saturation

This block takes wide signed samples from a filter datapath and reduces them to audio output words of 24 or 20 bits. The input carries two guard bits above the output full-scale position, so a sample that has grown past full scale can still be told apart from a sample that is in range. Before the low bits are dropped, the block adds a rounding value. This value is either exactly half of an output LSB, or a pseudo-random fraction of one output LSB that is uniformly distributed. An internal linear feedback shift register (LFSR) supplies the random fraction. If a result does not fit the output width, it is clamped to the largest positive code or the most negative code.

The rounding mode and the output length come from one of two sources. The first is a pair of pins. The second is a pair of register flags that are loaded through a write strobe. A select input chooses the source. The dither control is active high on the pin and active low on the flag. A 20-bit result is placed at the top of the 24-bit output port. Each accepted sample produces one registered result in the next cycle.

Top module: `rnd_out_top`

## Requirements
- R1: The input is a 34-bit two's-complement value x with output full scale at bit 31. Let D be 8 for a 24-bit word and 12 for a 20-bit word. With plain rounding, the word is floor((x + 2^(D-1)) / 2^D).
- R2: With dither rounding, the word is floor((x + r) / 2^D). Here r is the LFSR state shifted right by 16-D. The LFSR has 16 bits and resets to 0xACE1. It steps as s <= {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R3: A rounded result above 2^(W-1)-1 gives the maximum positive code, and a result below -2^(W-1) gives the minimum code. W is the selected word width.
- R4: A length control of 1 selects 24 bits on rnd_data_o[23:0]. A length control of 0 selects 20 bits on rnd_data_o[23:4], and rnd_data_o[3:0] are then 0.
- R5: With src_pin_i=1, dith_pin_i=1 selects dither and len_pin_i sets the length, and the flags have no effect. With src_pin_i=0, a dither flag of 0 selects dither and the length flag sets the length, and the two pins have no effect.
- R6: After reset, rnd_valid_o and rnd_data_o are 0, the dither flag is 1 (plain rounding), and the length flag is 0 (20 bits).
- R7: A sample accepted with smp_valid_i=1 appears on rnd_data_o with rnd_valid_o=1 one cycle later. In a cycle without a sample, rnd_valid_o goes low and rnd_data_o holds its value.
- R8: The LFSR steps exactly once for each accepted sample, in every mode, and does not step in idle cycles.
- R9: flag_wr_i=1 loads flag_dith_i and flag_len_i on the clock edge. Samples accepted in later cycles use the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | IN_W (34) | Wide signed sample |
| src_pin_i | input | 1 | 1: pins control the mode, 0: flags control the mode |
| len_pin_i | input | 1 | Pin length select (1 = 24 bits) |
| dith_pin_i | input | 1 | Pin dither enable (active high) |
| flag_wr_i | input | 1 | Load strobe for both flags |
| flag_len_i | input | 1 | Length flag value (1 = 24 bits) |
| flag_dith_i | input | 1 | Dither flag value (0 = dither) |
| rnd_valid_o | output | 1 | Result strobe |
| rnd_data_o | output | OUT_W (24) | Rounded and saturated word |

## Verification
If the LFSR stepped wrongly or was reseeded, every later dithered word would show the error on the first sample of the wrong step. An LFSR that stepped in idle cycles would be caught by the first dithered sample after an idle cycle. A flag register loaded at the wrong moment, or reset to the wrong value, changes the rounding offset or the word width of the very next sample. A fault in the overflow detection only shows on samples that are near or beyond full scale. For that reason the sweeps place values on each side of both clamp thresholds and of both rounding thresholds, for each length and each mode.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic {
    LEN_SHORT = 1'b0,
    LEN_LONG  = 1'b1
  } out_len_e;

  typedef struct packed {
    logic     dith_en;
    out_len_e len;
  } rnd_mode_t;

  // Feedback masks for maximal-length Fibonacci LFSRs, bit i = tap on state[i]
  function automatic logic [31:0] lfsr_taps(input int unsigned width);
    case (width)
      17:      lfsr_taps = 32'h0001_2000;
      18:      lfsr_taps = 32'h0002_0400;
      20:      lfsr_taps = 32'h0009_0000;
      24:      lfsr_taps = 32'h00E1_0000;
      default: lfsr_taps = 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import rnd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_pin_i,
  input  logic      len_pin_i,
  input  logic      dith_pin_i,
  input  logic      flag_wr_i,
  input  logic      flag_len_i,
  input  logic      flag_dith_i,
  output rnd_mode_t mode_o
);

  logic     dith_flag_q, dith_flag_d;
  out_len_e len_flag_q, len_flag_d;

  always_comb begin
    dith_flag_d = dith_flag_q;
    len_flag_d  = len_flag_q;
    if (flag_wr_i) begin
      dith_flag_d = flag_dith_i;
      len_flag_d  = out_len_e'(flag_len_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dith_flag_q <= 1'b1;
      len_flag_q  <= LEN_SHORT;
    end else begin
      dith_flag_q <= dith_flag_d;
      len_flag_q  <= len_flag_d;
    end
  end

  // Pin dither is active high, flag dither is active low
  always_comb begin
    if (src_pin_i) begin
      mode_o.dith_en = dith_pin_i;
      mode_o.len     = out_len_e'(len_pin_i);
    end else begin
      mode_o.dith_en = ~dith_flag_q;
      mode_o.len     = len_flag_q;
    end
  end

endmodule

// File: rtl/rnd_lfsr.sv
module rnd_lfsr #(
  parameter int unsigned LFSR_W    = 16,
  parameter logic [31:0] LFSR_SEED = 32'h0000_ACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);

  localparam logic [31:0]       TAPS_ALL = rnd_pkg::lfsr_taps(LFSR_W);
  localparam logic [LFSR_W-1:0] TAPS     = TAPS_ALL[LFSR_W-1:0];
  localparam logic [LFSR_W-1:0] SEED     = LFSR_SEED[LFSR_W-1:0];

  logic [LFSR_W-1:0] state_q, state_d;
  logic              fb;

  always_comb begin
    fb      = ^(state_q & TAPS);
    state_d = state_q;
    if (step_i) state_d = {state_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/rnd_core.sv
module rnd_core
  import rnd_pkg::*;
#(
  parameter int unsigned IN_W    = 34,
  parameter int unsigned GUARD_W = 2,
  parameter int unsigned OUT_W   = 24,
  parameter int unsigned SHORT_W = 20,
  parameter int unsigned LFSR_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   data_i,
  input  rnd_mode_t         mode_i,
  input  logic [LFSR_W-1:0] rand_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o
);

  localparam int unsigned SIGN_POS = IN_W - 1 - GUARD_W;
  localparam int unsigned D_LONG   = SIGN_POS + 1 - OUT_W;
  localparam int unsigned D_SHORT  = SIGN_POS + 1 - SHORT_W;
  localparam int unsigned PAD_W    = OUT_W - SHORT_W;
  localparam int unsigned SUM_W    = IN_W + 1;

  localparam logic [SUM_W-1:0] ONE        = SUM_W'(1);
  localparam logic [SUM_W-1:0] HALF_LONG  = ONE << (D_LONG - 1);
  localparam logic [SUM_W-1:0] HALF_SHORT = ONE << (D_SHORT - 1);

  localparam logic [OUT_W-1:0] POS_LONG  = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] NEG_LONG  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] POS_SHORT = {1'b0, {(SHORT_W-1){1'b1}}, {PAD_W{1'b0}}};
  localparam logic [OUT_W-1:0] NEG_SHORT = {1'b1, {(SHORT_W-1){1'b0}}, {PAD_W{1'b0}}};

  logic [SUM_W-1:0] dith_long, dith_short;

  // Random fraction aligned just below the output LSB for each word length
  generate
    if (LFSR_W >= D_LONG) begin : g_dl_trunc
      assign dith_long = SUM_W'(rand_i >> (LFSR_W - D_LONG));
    end else begin : g_dl_pad
      assign dith_long = SUM_W'(rand_i) << (D_LONG - LFSR_W);
    end
    if (LFSR_W >= D_SHORT) begin : g_ds_trunc
      assign dith_short = SUM_W'(rand_i >> (LFSR_W - D_SHORT));
    end else begin : g_ds_pad
      assign dith_short = SUM_W'(rand_i) << (D_SHORT - LFSR_W);
    end
  endgenerate

  logic [SUM_W-1:0]       addend;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] long_q, short_q;
  logic [SUM_W-OUT_W:0]   long_top;
  logic [SUM_W-SHORT_W:0] short_top;
  logic                   ovf_long, ovf_short;
  logic [OUT_W-1:0]       word_long, word_short, word_d;
  logic                   valid_d;

  always_comb begin
    if (mode_i.dith_en) addend = (mode_i.len == LEN_LONG) ? dith_long : dith_short;
    else                addend = (mode_i.len == LEN_LONG) ? HALF_LONG : HALF_SHORT;

    sum     = $signed({data_i[IN_W-1], data_i}) + $signed(addend);
    long_q  = sum >>> D_LONG;
    short_q = sum >>> D_SHORT;

    long_top  = long_q[SUM_W-1:OUT_W-1];
    short_top = short_q[SUM_W-1:SHORT_W-1];
    ovf_long  = ~((&long_top) | ~(|long_top));
    ovf_short = ~((&short_top) | ~(|short_top));

    if (ovf_long) word_long = long_q[SUM_W-1] ? NEG_LONG : POS_LONG;
    else          word_long = long_q[OUT_W-1:0];

    if (ovf_short) word_short = short_q[SUM_W-1] ? NEG_SHORT : POS_SHORT;
    else           word_short = {short_q[SHORT_W-1:0], {PAD_W{1'b0}}};

    valid_d = valid_i;
    word_d  = data_o;
    if (valid_i) word_d = (mode_i.len == LEN_LONG) ? word_long : word_short;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_d;
      data_o  <= word_d;
    end
  end

endmodule

// File: rtl/rnd_out_top.sv
module rnd_out_top
  import rnd_pkg::*;
#(
  parameter int unsigned IN_W      = 34,
  parameter int unsigned GUARD_W   = 2,
  parameter int unsigned OUT_W     = 24,
  parameter int unsigned SHORT_W   = 20,
  parameter int unsigned LFSR_W    = 16,
  parameter logic [31:0] LFSR_SEED = 32'h0000_ACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [IN_W-1:0]  smp_data_i,
  input  logic             src_pin_i,
  input  logic             len_pin_i,
  input  logic             dith_pin_i,
  input  logic             flag_wr_i,
  input  logic             flag_len_i,
  input  logic             flag_dith_i,
  output logic             rnd_valid_o,
  output logic [OUT_W-1:0] rnd_data_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  rnd_mode_t         mode;
  logic [LFSR_W-1:0] rand_state;

  rnd_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .src_pin_i   (src_pin_i),
    .len_pin_i   (len_pin_i),
    .dith_pin_i  (dith_pin_i),
    .flag_wr_i   (flag_wr_i),
    .flag_len_i  (flag_len_i),
    .flag_dith_i (flag_dith_i),
    .mode_o      (mode)
  );

  rnd_lfsr #(
    .LFSR_W    (LFSR_W),
    .LFSR_SEED (LFSR_SEED)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .step_i  (smp_valid_i),
    .state_o (rand_state)
  );

  rnd_core #(
    .IN_W    (IN_W),
    .GUARD_W (GUARD_W),
    .OUT_W   (OUT_W),
    .SHORT_W (SHORT_W),
    .LFSR_W  (LFSR_W)
  ) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .valid_i (smp_valid_i),
    .data_i  (smp_data_i),
    .mode_i  (mode),
    .rand_i  (rand_state),
    .valid_o (rnd_valid_o),
    .data_o  (rnd_data_o)
  );

endmodule

// File: rtl/rnd_out_chk.sv
module rnd_out_chk #(
  parameter int unsigned IN_W   = 34,
  parameter int unsigned OUT_W  = 24,
  parameter int unsigned PAD_W  = 4,
  parameter int unsigned LFSR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_sign,
  input logic              src_pin,
  input logic              len_pin,
  input logic              flag_wr,
  input logic [1:0]        flags,
  input logic              rnd_valid,
  input logic [OUT_W-1:0]  rnd_data,
  input logic [LFSR_W-1:0] lfsr_q
);

  // R7: a result strobe follows each accepted sample
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> rnd_valid);

  // R7: idle cycle drops the strobe and holds the word
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> (!rnd_valid && $stable(rnd_data)));

  // R4: short words carry zero padding
  p_short_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && src_pin && !len_pin) |=> (rnd_data[PAD_W-1:0] == '0));

  // R3: a non-negative sample never wraps to a negative word
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_sign) |=> !rnd_data[OUT_W-1]);

  // R8: random source frozen in idle cycles
  p_lfsr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(lfsr_q));

  // R2: random source never locks up in the all-zero state
  p_lfsr_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R9: flags change only on a write
  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> $stable(flags));

endmodule

bind rnd_out_top rnd_out_chk #(
  .IN_W   (IN_W),
  .OUT_W  (OUT_W),
  .PAD_W  (OUT_W - SHORT_W),
  .LFSR_W (LFSR_W)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n),
  .smp_valid (smp_valid_i),
  .smp_sign  (smp_data_i[IN_W-1]),
  .src_pin   (src_pin_i),
  .len_pin   (len_pin_i),
  .flag_wr   (flag_wr_i),
  .flags     ({u_ctrl.dith_flag_q, u_ctrl.len_flag_q}),
  .rnd_valid (rnd_valid_o),
  .rnd_data  (rnd_data_o),
  .lfsr_q    (rand_state)
);

// File: tb/sim_rnd_out_top.sv
`timescale 1ns/1ps
module sim_rnd_out_top;

  localparam int IN_W = 34;
  localparam int OUT_W = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic [IN_W-1:0]  smp_data = '0;
  logic             src_pin = 1'b0, len_pin = 1'b0, dith_pin = 1'b0;
  logic             flag_wr = 1'b0, flag_len = 1'b0, flag_dith = 1'b0;
  logic             rnd_valid;
  logic [OUT_W-1:0] rnd_data;

  rnd_out_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .src_pin_i(src_pin), .len_pin_i(len_pin), .dith_pin_i(dith_pin),
    .flag_wr_i(flag_wr), .flag_len_i(flag_len), .flag_dith_i(flag_dith),
    .rnd_valid_o(rnd_valid), .rnd_data_o(rnd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] model_lfsr;
  bit fl_dith, fl_len;

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic calc(input longint v, input bit dith, input bit l24, input logic [15:0] r,
                      output logic [23:0] word, output bit sat);
    int d, w;
    longint add, q, hi, lo;
    d = l24 ? 8 : 12;
    w = l24 ? 24 : 20;
    add = dith ? longint'(r >> (16 - d)) : (longint'(1) << (d - 1));
    q = (v + add) >>> d;
    hi = (longint'(1) << (w - 1)) - 1;
    lo = -(longint'(1) << (w - 1));
    sat = 1'b0;
    if (q > hi) begin q = hi; sat = 1'b1; end
    if (q < lo) begin q = lo; sat = 1'b1; end
    word = 24'(q << (24 - w));
  endtask

  task automatic send(input longint v, input string req);
    bit ed, el, sat;
    logic [23:0] exp;
    string tag;
    ed = src_pin ? dith_pin : !fl_dith;
    el = src_pin ? len_pin : fl_len;
    calc(v, ed, el, model_lfsr, exp, sat);
    model_lfsr = lfsr_next(model_lfsr);
    smp_valid = 1'b1;
    smp_data = v[IN_W-1:0];
    @(negedge clk);
    smp_valid = 1'b0;
    tag = (req != "") ? req : (sat ? "R3" : (ed ? "R2" : "R1"));
    check(rnd_valid === 1'b1, "R7", longint'(rnd_valid), 1);
    check(rnd_data === exp, tag, longint'(rnd_data), longint'(exp));
    if (!el) check(rnd_data[3:0] === 4'h0, "R4", longint'(rnd_data[3:0]), 0);
  endtask

  task automatic idle();
    logic [23:0] prev;
    prev = rnd_data;
    smp_valid = 1'b0;
    @(negedge clk);
    check(rnd_valid === 1'b0, "R7", longint'(rnd_valid), 0);
    check(rnd_data === prev, "R7", longint'(rnd_data), longint'(prev));
  endtask

  task automatic wr_flags(input bit d, input bit l);
    flag_wr = 1'b1; flag_dith = d; flag_len = l;
    @(negedge clk);
    flag_wr = 1'b0;
    fl_dith = d; fl_len = l;
  endtask

  task automatic sweep_edges();
    longint fs, h, one_lsb;
    longint e[16];
    int d;
    d = (src_pin ? len_pin : fl_len) ? 8 : 12;
    fs = longint'(1) << 31;
    h = longint'(1) << (d - 1);
    one_lsb = longint'(1) << d;
    e[0] = fs - 1;        e[1] = fs - h - 1;   e[2] = fs - h;     e[3] = fs;
    e[4] = (longint'(1) << 33) - 1;            e[5] = -fs;        e[6] = -fs - 1;
    e[7] = -(longint'(1) << 33);               e[8] = 0;          e[9] = -1;
    e[10] = h - 1;        e[11] = h;           e[12] = -h;        e[13] = -h - 1;
    e[14] = 3 * one_lsb + h - 1;               e[15] = -5 * one_lsb + h;
    foreach (e[k]) send(e[k], "");
  endtask

  task automatic sweep_hash(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      logic [63:0] x;
      longint v;
      x = 64'(base + i) * 64'h9E37_79B9_7F4A_7C15;
      if (i % 8 == 7) v = longint'($signed(x[63:30]));
      else            v = longint'($signed(x[63:32]));
      if (i % 29 == 13) begin
        idle();
        send(v, "R8");
      end else begin
        send(v, "");
      end
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_lfsr = 16'hACE1;
    fl_dith = 1'b1;
    fl_len = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(rnd_valid === 1'b0, "R6", longint'(rnd_valid), 0);
    check(rnd_data === 24'h0, "R6", longint'(rnd_data), 0);

    // Flag mode with reset defaults: plain rounding, 20-bit words
    send(64'sd123456789, "R6");
    send(-64'sd2049, "R6");
    send(64'sd2048, "R6");

    for (int s = 0; s < 2; s++) begin
      for (int dsel = 0; dsel < 2; dsel++) begin
        for (int l = 0; l < 2; l++) begin
          src_pin = s[0];
          if (s == 1) begin
            dith_pin = dsel[0];
            len_pin = l[0];
          end else begin
            wr_flags(~dsel[0], l[0]);
            send(64'sd987654321, "R9");
          end
          sweep_edges();
          sweep_hash(150, 1000 * (4 * s + 2 * dsel + l));
          // Inactive source must not matter
          if (s == 1) begin
            wr_flags(dsel[0], ~l[0]);
          end else begin
            dith_pin = ~dith_pin;
            len_pin = ~len_pin;
          end
          send(64'sd555555555, "R5");
          send(-64'sd777777777, "R5");
          send(64'sd2147483000, "R5");
          send(-64'sd4095, "R5");
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule